// File: doc/BRIEF.md
# Flash Block Write-Protection Lock Controller

This block keeps the write-protection state of a byte-wide flash array divided into equal erase blocks, sixteen of 64 KB by default. Each block has its own lock bit, and one device-wide master lock sits above them. The master lock can be set but never cleared. Lock changes arrive as two-write command sequences on a bus write port. The first write is always the setup byte 60H. The second write picks the operation: lock one block, lock the master, or unlock every block together.

An erase/program engine asks the block whether a given block may be altered. An identifier-read path reads the lock state of a block and of the master. Each accepted lock operation raises a busy output for a fixed number of cycles and then takes effect. Errors are reported on the bits of a status byte. An abort input can cancel an operation in flight. A bulk unlock that is cut short leaves the block bits undefined. Until a later unlock completes, every block is reported as locked.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset, busy is 0, status reads 80H, no block or master lock is set, and qry_protect is 0.
- R2: Writing 60H and then 01H locks one block: the block selected by wr_addr[19:16] on the second write. The change takes effect when busy falls, and id_blk_locked then reads 1 for that block.
- R3: Writing 60H and then D0H unlocks all block bits together when busy falls. The address on either write does not matter.
- R4: Writing 60H and then F1H sets the master lock. Apart from reset, no command sequence clears it.
- R5: If the master lock is set and rp_hv is 0, a lock or unlock sequence makes no change and busy stays low. It sets status bit 1 together with status bit 4 (lock or master) or status bit 5 (unlock). When rp_hv is 1, the sequence is accepted.
- R6: If vpp_ok is 0 on the second write, status bit 3 is set, no lock bit changes and busy stays low.
- R7: A second byte other than 01H, F1H or D0H sets status bits 4 and 5. No lock bit changes and busy stays low.
- R8: Busy rises on the cycle after the second write and stays high for BUSY_CYC cycles. Status bit 7 reads the inverse of busy. Writes made while busy is high are ignored.
- R9: Asserting abort_req while busy is high drops busy on the next cycle and applies no change. This holds even when the abort falls on the completion cycle. Aborting an unlock also sets status bit 5 and marks all blocks as locked on id_blk_locked and qry_protect, until a later unlock completes.
- R10: qry_protect is 1 exactly when block qry_blk is locked (or undefined) and rp_hv is 0.
- R11: An accepted 60H setup write clears status bits 5, 4, 3 and 1. In idle, any other byte is ignored. Status bits 6, 2 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address; the top bits select the block |
| wr_data | input | 8 | Bus write data (command byte) |
| vpp_ok | input | 1 | Program supply is valid |
| rp_hv | input | 1 | Reset pin is at its high-voltage override level |
| abort_req | input | 1 | Cancel the operation in flight |
| qry_blk | input | BW | Block index asked about by the erase/program engine |
| qry_protect | output | 1 | The queried block may not be altered |
| id_blk | input | BW | Block index for an identifier read |
| id_blk_locked | output | 1 | Lock state of block id_blk |
| id_master_locked | output | 1 | Master lock state |
| busy | output | 1 | A lock operation is in progress |
| status | output | 8 | Status byte: 7 ready, 5 unlock error, 4 lock error, 3 supply error, 1 protect error |

## Verification
The case of interest is an abort that lands on the completion cycle of an operation. The abort is driven on the exact edge at which the busy counter would finish and apply the change. Its effect is judged through id_blk_locked: the target block must stay unlocked and busy must fall. A second case is a write that arrives while busy is high. It is sent as a fresh 60H setup, followed after completion by a would-be confirm byte. That confirm byte must leave both the status byte and the lock bits unchanged.

// File: rtl/lk_pkg.sv
package lk_pkg;
  typedef enum logic [1:0] {
    OP_SET_BLK = 2'd0,
    OP_SET_MST = 2'd1,
    OP_CLR_ALL = 2'd2
  } lk_op_e;

  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CONF_BLK   = 8'h01;
  localparam logic [7:0] CONF_MST   = 8'hF1;
  localparam logic [7:0] CONF_CLR   = 8'hD0;

  typedef struct packed {
    logic clr_err;
    logic set_err;
    logic vpp_err;
    logic prot_err;
  } lk_flags_t;
endpackage

// File: rtl/lk_seq.sv
module lk_seq
  import lk_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic [7:0]    wr_data,
  input  logic          busy,
  input  logic          abort_req,
  input  logic          vpp_ok,
  input  logic          rp_hv,
  input  logic          master,
  input  logic          clr_aborted,
  output logic          launch,
  output lk_op_e        launch_op,
  output logic [BW-1:0] launch_blk,
  output lk_flags_t     flags
);
  logic      armed_q, armed_d;
  lk_flags_t flags_q, flags_d;
  logic      conf_ok;

  always_comb begin
    armed_d    = armed_q;
    flags_d    = flags_q;
    launch     = 1'b0;
    launch_op  = OP_SET_BLK;
    launch_blk = wr_blk;
    conf_ok    = 1'b1;
    unique case (wr_data)
      CONF_BLK: launch_op = OP_SET_BLK;
      CONF_MST: launch_op = OP_SET_MST;
      CONF_CLR: launch_op = OP_CLR_ALL;
      default:  conf_ok   = 1'b0;
    endcase
    if (abort_req) begin
      armed_d = 1'b0;
    end else if (wr_en && !busy) begin
      if (!armed_q) begin
        if (wr_data == CMD_SETUP) begin
          armed_d = 1'b1;
          flags_d = '0;
        end
      end else begin
        armed_d = 1'b0;
        if (!conf_ok) begin
          flags_d.set_err = 1'b1;
          flags_d.clr_err = 1'b1;
        end else if (!vpp_ok) begin
          flags_d.vpp_err = 1'b1;
        end else if (master && !rp_hv) begin
          flags_d.prot_err = 1'b1;
          if (launch_op == OP_CLR_ALL) flags_d.clr_err = 1'b1;
          else                         flags_d.set_err = 1'b1;
        end else begin
          launch = 1'b1;
        end
      end
    end
    if (clr_aborted) flags_d.clr_err = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flags_q <= '0;
    end else begin
      armed_q <= armed_d;
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/lk_timer.sv
module lk_timer
  import lk_pkg::*;
#(
  parameter int BUSY_CYC = 8,
  parameter int BW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  lk_op_e        launch_op,
  input  logic [BW-1:0] launch_blk,
  input  logic          abort_req,
  output logic          busy,
  output logic          done,
  output lk_op_e        cur_op,
  output logic [BW-1:0] cur_blk,
  output logic          clr_aborted
);
  localparam int CW = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  lk_op_e        op_q, op_d;
  logic [BW-1:0] blk_q, blk_d;
  logic          load_en;

  assign load_en     = launch && !busy_q;
  assign done        = busy_q && (cnt_q == '0) && !abort_req;
  assign clr_aborted = busy_q && abort_req && (op_q == OP_CLR_ALL);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    blk_d  = blk_q;
    if (load_en) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      op_d   = launch_op;
      blk_d  = launch_blk;
    end else if (busy_q) begin
      if (abort_req || (cnt_q == '0)) busy_d = 1'b0;
      else                            cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_SET_BLK;
      blk_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      blk_q  <= blk_d;
    end
  end

  assign busy    = busy_q;
  assign cur_op  = op_q;
  assign cur_blk = blk_q;
endmodule

// File: rtl/lk_store.sv
module lk_store
  import lk_pkg::*;
#(
  parameter int NUM_BLK = 16,
  parameter int BW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done,
  input  lk_op_e             op,
  input  logic [BW-1:0]      blk,
  input  logic               clr_aborted,
  input  logic               rp_hv,
  input  logic [BW-1:0]      qry_blk,
  input  logic [BW-1:0]      id_blk,
  output logic [NUM_BLK-1:0] lock_vec,
  output logic               master,
  output logic               qry_protect,
  output logic               id_blk_locked
);
  logic [NUM_BLK-1:0] lock_q, lock_d;
  logic               mst_q, mst_d, undef_q, undef_d;
  logic               set_hit, clr_hit;

  assign set_hit = done && (op == OP_SET_BLK);
  assign clr_hit = done && (op == OP_CLR_ALL);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
    always_comb begin
      lock_d[i] = lock_q[i];
      if (clr_hit)                                 lock_d[i] = 1'b0;
      else if (set_hit && (blk == BW'(i)))         lock_d[i] = 1'b1;
    end
  end

  always_comb begin
    mst_d   = mst_q || (done && (op == OP_SET_MST));
    undef_d = undef_q;
    if (clr_aborted)  undef_d = 1'b1;
    else if (clr_hit) undef_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      mst_q   <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      mst_q   <= mst_d;
      undef_q <= undef_d;
    end
  end

  assign lock_vec      = lock_q;
  assign master        = mst_q;
  assign qry_protect   = (lock_q[qry_blk] || undef_q) && !rp_hv;
  assign id_blk_locked = lock_q[id_blk] || undef_q;
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import lk_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int NUM_BLK  = 16,
  parameter int BUSY_CYC = 8,
  parameter int BW       = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vpp_ok,
  input  logic              rp_hv,
  input  logic              abort_req,
  input  logic [BW-1:0]     qry_blk,
  output logic              qry_protect,
  input  logic [BW-1:0]     id_blk,
  output logic              id_blk_locked,
  output logic              id_master_locked,
  output logic              busy,
  output logic [7:0]        status
);
  logic               launch, done, clr_aborted, master;
  lk_op_e             launch_op, cur_op;
  logic [BW-1:0]      launch_blk, cur_blk, wr_blk;
  lk_flags_t          flags;
  logic [NUM_BLK-1:0] lock_vec;
  logic               unused_addr;

  assign wr_blk      = wr_addr[ADDR_W-1 -: BW];
  assign unused_addr = ^wr_addr[ADDR_W-BW-1:0];

  lk_seq #(.BW(BW)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk), .wr_data(wr_data),
    .busy(busy), .abort_req(abort_req), .vpp_ok(vpp_ok), .rp_hv(rp_hv),
    .master(master), .clr_aborted(clr_aborted), .launch(launch),
    .launch_op(launch_op), .launch_blk(launch_blk), .flags(flags)
  );

  lk_timer #(.BUSY_CYC(BUSY_CYC), .BW(BW)) timer_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .launch_blk(launch_blk), .abort_req(abort_req), .busy(busy), .done(done),
    .cur_op(cur_op), .cur_blk(cur_blk), .clr_aborted(clr_aborted)
  );

  lk_store #(.NUM_BLK(NUM_BLK), .BW(BW)) store_i (
    .clk(clk), .rst_n(rst_n), .done(done), .op(cur_op), .blk(cur_blk),
    .clr_aborted(clr_aborted), .rp_hv(rp_hv), .qry_blk(qry_blk), .id_blk(id_blk),
    .lock_vec(lock_vec), .master(master), .qry_protect(qry_protect),
    .id_blk_locked(id_blk_locked)
  );

  assign id_master_locked = master;
  assign status = {~busy, 1'b0, flags.clr_err, flags.set_err, flags.vpp_err,
                   1'b0, flags.prot_err, 1'b0};
endmodule

// File: rtl/blk_lock_ctrl_chk.sv
module blk_lock_ctrl_chk #(
  parameter int NUM_BLK = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               busy,
  input logic               abort_req,
  input logic               vpp_ok,
  input logic               rp_hv,
  input logic               id_master_locked,
  input logic [NUM_BLK-1:0] lock_vec
);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R4
  master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_master_locked |=> id_master_locked);

  // R9
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_req) |=> !busy);

  // R6
  vpp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !vpp_ok) |=> !busy);

  // R5
  master_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && id_master_locked && !rp_hv) |=> !busy);

  // R2
  bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(lock_vec));
endmodule

bind blk_lock_ctrl blk_lock_ctrl_chk #(.NUM_BLK(NUM_BLK)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .abort_req(abort_req),
  .vpp_ok(vpp_ok), .rp_hv(rp_hv), .id_master_locked(id_master_locked),
  .lock_vec(lock_vec)
);

// File: tb/blk_lock_ctrl_tb.sv
module blk_lock_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic vpp_ok = 1'b1, rp_hv = 1'b0, abort_req = 1'b0;
  logic [3:0] qry_blk = '0, id_blk = '0;
  logic qry_protect, id_blk_locked, id_master_locked, busy;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .rp_hv(rp_hv), .abort_req(abort_req), .qry_blk(qry_blk),
    .qry_protect(qry_protect), .id_blk(id_blk), .id_blk_locked(id_blk_locked),
    .id_master_locked(id_master_locked), .busy(busy), .status(status)
  );

  // behavioural reference model
  int m_lock[16];
  int m_master, m_undef, m_busy, m_cnt, m_op, m_blk, m_armed;
  int f_clr, f_set, f_vpp, f_prot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lock[i]) m_lock[i] = 0;
      m_master = 0; m_undef = 0; m_busy = 0; m_cnt = 0; m_op = 0; m_blk = 0;
      m_armed = 0; f_clr = 0; f_set = 0; f_vpp = 0; f_prot = 0;
    end else if (m_busy != 0) begin
      if (abort_req) begin
        m_busy = 0;
        if (m_op == 2) begin m_undef = 1; f_clr = 1; end
      end else if (m_cnt == 0) begin
        m_busy = 0;
        if (m_op == 0) m_lock[m_blk] = 1;
        else if (m_op == 1) m_master = 1;
        else begin foreach (m_lock[i]) m_lock[i] = 0; m_undef = 0; end
      end else m_cnt = m_cnt - 1;
    end else if (abort_req) begin
      m_armed = 0;
    end else if (wr_en) begin
      if (m_armed == 0) begin
        if (wr_data == 8'h60) begin
          m_armed = 1; f_clr = 0; f_set = 0; f_vpp = 0; f_prot = 0;
        end
      end else begin
        int op;
        m_armed = 0;
        op = (wr_data == 8'h01) ? 0 : (wr_data == 8'hF1) ? 1 : (wr_data == 8'hD0) ? 2 : 3;
        if (op == 3) begin f_set = 1; f_clr = 1; end
        else if (!vpp_ok) f_vpp = 1;
        else if (m_master != 0 && !rp_hv) begin
          f_prot = 1;
          if (op == 2) f_clr = 1; else f_set = 1;
        end else begin
          m_busy = 1; m_cnt = BUSY - 1; m_op = op; m_blk = int'(wr_addr[19:16]);
        end
      end
    end
  end

  function automatic logic [7:0] exp_status();
    return {(m_busy == 0), 1'b0, f_clr[0], f_set[0], f_vpp[0], 1'b0, f_prot[0], 1'b0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 busy", int'(busy), int'(m_busy != 0));
      chk("R11 status", int'(status), int'(exp_status()));
      chk("R10 qry_protect", int'(qry_protect),
          int'((m_lock[qry_blk] != 0 || m_undef != 0) && !rp_hv));
      chk("R2 id_blk_locked", int'(id_blk_locked), int'(m_lock[id_blk] != 0 || m_undef != 0));
      chk("R4 id_master_locked", int'(id_master_locked), m_master);
    end
  end

  task automatic drive_wr(input logic [7:0] d, input logic [3:0] b);
    @(posedge clk); #(CLK_PERIOD/4);
    wr_en = 1'b1; wr_data = d; wr_addr = {b, 16'h1234};
    @(posedge clk); #(CLK_PERIOD/4);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic look(input logic [3:0] b);
    id_blk = b; qry_blk = b;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(status), 8'h80);
    chk("R1 busy", int'(busy), 0);
    chk("R1 master", int'(id_master_locked), 0);
    chk("R1 qry_protect", int'(qry_protect), 0);

    // R2 lock block 5, R8 busy timing and ignored writes
    drive_wr(8'h60, 4'h0);
    drive_wr(8'h01, 4'h5);
    @(negedge clk);
    chk("R8 busy after confirm", int'(busy), 1);
    drive_wr(8'h60, 4'h0);
    idle(BUSY);
    drive_wr(8'h01, 4'h9);
    idle(1);
    look(4'h5);
    chk("R2 block5 locked", int'(id_blk_locked), 1);
    chk("R10 protect rp low", int'(qry_protect), 1);
    rp_hv = 1'b1;
    @(negedge clk);
    chk("R10 protect rp high", int'(qry_protect), 0);
    rp_hv = 1'b0;
    look(4'h9);
    chk("R8 write while busy ignored", int'(id_blk_locked), 0);
    chk("R11 idle byte ignored", int'(status), 8'h80);
    look(4'h6);
    chk("R10 other block free", int'(qry_protect), 0);

    // R3 bulk unlock
    drive_wr(8'h60, 4'h0); drive_wr(8'h01, 4'hC); idle(BUSY + 1);
    look(4'hC);
    chk("R2 block12 locked", int'(id_blk_locked), 1);
    drive_wr(8'h60, 4'h3); drive_wr(8'hD0, 4'h7); idle(BUSY + 1);
    look(4'hC);
    chk("R3 block12 cleared", int'(id_blk_locked), 0);
    look(4'h5);
    chk("R3 block5 cleared", int'(id_blk_locked), 0);

    // R7 bad confirm
    drive_wr(8'h60, 4'h0); drive_wr(8'h55, 4'h2);
    @(negedge clk);
    chk("R7 status", int'(status), 8'hB0);
    chk("R7 no busy", int'(busy), 0);

    // R6 supply invalid
    vpp_ok = 1'b0;
    drive_wr(8'h60, 4'h0); drive_wr(8'h01, 4'h3);
    vpp_ok = 1'b1;
    idle(2);
    look(4'h3);
    chk("R6 status", int'(status), 8'h88);
    chk("R6 no change", int'(id_blk_locked), 0);
    drive_wr(8'h60, 4'h0);
    @(negedge clk);
    chk("R11 flags cleared", int'(status), 8'h80);
    drive_wr(8'h00, 4'h0);

    // R9 aborted unlock
    drive_wr(8'h60, 4'h0); drive_wr(8'h01, 4'h2); idle(BUSY + 1);
    drive_wr(8'h60, 4'h0); drive_wr(8'hD0, 4'h0);
    idle(2);
    abort_req = 1'b1; idle(1); abort_req = 1'b0;
    look(4'h7);
    chk("R9 busy dropped", int'(busy), 0);
    chk("R9 status", int'(status), 8'hA0);
    chk("R9 undefined as locked", int'(id_blk_locked), 1);
    chk("R9 query protected", int'(qry_protect), 1);
    drive_wr(8'h60, 4'h0); drive_wr(8'hD0, 4'h0); idle(BUSY + 1);
    look(4'h7);
    chk("R9 recovered", int'(id_blk_locked), 0);

    // R9 abort on the completion cycle
    drive_wr(8'h60, 4'h0);
    @(posedge clk); #(CLK_PERIOD/4);
    wr_en = 1'b1; wr_data = 8'h01; wr_addr = {4'h4, 16'h0};
    @(posedge clk); #(CLK_PERIOD/4);
    wr_en = 1'b0;
    for (int i = 0; i < BUSY - 1; i++) @(posedge clk);
    #(CLK_PERIOD/4);
    abort_req = 1'b1; idle(1); abort_req = 1'b0;
    look(4'h4);
    chk("R9 completion abort busy", int'(busy), 0);
    chk("R9 completion abort no lock", int'(id_blk_locked), 0);

    // R4 master, R5 protection
    drive_wr(8'h60, 4'h0); drive_wr(8'hF1, 4'h0); idle(BUSY + 1);
    @(negedge clk);
    chk("R4 master set", int'(id_master_locked), 1);
    drive_wr(8'h60, 4'h0); drive_wr(8'h01, 4'h1);
    look(4'h1);
    chk("R5 set refused status", int'(status), 8'h92);
    chk("R5 set refused bit", int'(id_blk_locked), 0);
    rp_hv = 1'b1;
    drive_wr(8'h60, 4'h0); drive_wr(8'h01, 4'h1); idle(BUSY + 1);
    look(4'h1);
    chk("R5 override accepted", int'(id_blk_locked), 1);
    rp_hv = 1'b0;
    drive_wr(8'h60, 4'h0); drive_wr(8'hD0, 4'h0);
    look(4'h1);
    chk("R5 clear refused status", int'(status), 8'hA2);
    chk("R5 clear refused bit", int'(id_blk_locked), 1);
    rp_hv = 1'b1;
    drive_wr(8'h60, 4'h0); drive_wr(8'hD0, 4'h0); idle(BUSY + 1);
    look(4'h1);
    chk("R3 clear under override", int'(id_blk_locked), 0);
    chk("R4 master survives clear", int'(id_master_locked), 1);
    rp_hv = 1'b0;

    idle(4);
    summary();
    $finish;
  end
endmodule